// File: doc/BRIEF.md
# Gated Count Measurement Sequencer

This block runs the repeating measurement loop of an integrating counter-type meter. A loop has five phases. A clear pulse empties the counting decades. The block then waits armed for a time-base tick. The count gate stays open for the selected interval. The result is strobed into storage. The reading is held on display, and a fresh clear pulse then starts the next loop. The counting decades sit outside this block and follow its count-enable and clear outputs.

A fixed-rate reference tick (nominally 100 kHz) passes through free-running prescale decades to give the base tick (nominally 1 kHz). A second chain of decades, emptied at every clear, times the gate. Gate lengths of 10, 100 or 1000 base ticks can be chosen. The display hold length is set in base ticks, or it can be made endless. A manual reset, an external trigger edge or the end of the hold restarts the loop at any point. In external mode the automatic start is switched off, and separate start and stop commands open and close the gate.

Top module: `gated_meas_seq`

## Requirements
- R1: While rstN is low, and for exactly RST_CYC cycles after each restart request, counterClear is 1 and countEnable and displayHold are 0.
- R2: In automatic mode (extMode 0), the first base tick after the clear pulse ends starts counting when inhibit is 0. countEnable rises on the cycle after that tick.
- R3: While inhibit is 1 the automatic start does not occur. After inhibit falls, counting starts on the next base tick, within one base period.
- R4: The start tick counts as the first gate tick. countEnable stays high for (RADIX^(gateSel+1) - 1) base periods. gateSel 0, 1 and 2 give 10, 100 and 1000 ticks at default parameters, and gateSel 3 behaves as gateSel 2.
- R5: The gate decades are emptied by every clear pulse, so a gate that follows an aborted gate has the full length.
- R6: When the gate ends, countEnable falls, xferStrobe goes high for exactly XFER_CYC cycles and displayHold goes high, all in the same cycle.
- R7: The display hold lasts (holdSetting + 1) base periods. A clear pulse then follows by itself, and the next gate starts, so a whole loop lasts (gate ticks + holdSetting + 1) base periods.
- R8: With holdForever set, displayHold stays high until a manual reset or an external trigger edge.
- R9: manualReset at 1, or a 0-to-1 edge on extTrigger, raises counterClear on the next cycle from any phase. An extTrigger that stays high causes only one clear pulse.
- R10: A restart request raises xferStrobe only when it arrives while countEnable is high.
- R11: With extMode at 1 the gate never opens by itself. An extStart pulse opens it and the gate length is ignored. An extStop pulse closes it, and this raises xferStrobe and displayHold. extStart has no effect during the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous-free synchronous active-low reset |
| refTick | input | 1 | One-cycle pulse at the reference rate |
| gateSel | input | SEL_W | Gate length select: 0 shortest, larger values longer |
| holdSetting | input | HOLD_W | Display hold length minus one, in base ticks |
| holdForever | input | 1 | Keep the hold until a manual restart |
| inhibit | input | 1 | Blocks the automatic start while high |
| extMode | input | 1 | External start/stop operation |
| extStart | input | 1 | Opens the gate in external mode |
| extStop | input | 1 | Closes the gate in external mode |
| manualReset | input | 1 | Restart request, level |
| extTrigger | input | 1 | Restart request on its rising edge |
| countEnable | output | 1 | Count gate open |
| counterClear | output | 1 | Clears the counting decades |
| xferStrobe | output | 1 | Moves the count into storage |
| displayHold | output | 1 | Reading held on display |

## Verification
The bench builds the block with RADIX 4, a single prescale decade and a 3-bit hold field. It drives a reference tick every second clock, which gives a base period of 8 cycles and gates of 4, 16 and 64 ticks. These values make it feasible to sweep every gate select against every hold setting and to check each gate width, hold width and loop period as plain arithmetic. With 3-cycle clear pulses and 2-cycle strobes, the tests for abort, inhibit, endless hold, trigger edge and external mode each complete within a few hundred cycles.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [1:0] {
    PH_CLEAR = 2'd0,
    PH_ARMED = 2'd1,
    PH_COUNT = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  typedef struct packed {
    logic gateClr;   // empty the gate decades
    logic gateAdv;   // advance the gate decades by one base tick
    logic holdRun;   // hold timer active
    logic xferFire;  // launch the transfer strobe
  } ctlStrobe_t;

  function automatic int unsigned ipow(int unsigned base, int unsigned exp);
    int unsigned r = 1;
    for (int unsigned i = 0; i < exp; i++) r = r * base;
    return r;
  endfunction

endpackage

// File: rtl/mseq_dp.sv
module mseq_dp
  import mseq_pkg::*;
#(
  parameter int RADIX       = 10,
  parameter int PRE_STAGES  = 2,
  parameter int GATE_STAGES = 3,
  parameter int HOLD_W      = 13,
  parameter int XFER_CYC    = 1650,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [SEL_W-1:0]  gateSel,
  input  logic [HOLD_W-1:0] holdSetting,
  input  logic              holdForever,
  input  ctlStrobe_t        ctl,
  output logic              baseTick,
  output logic              gateEnd,
  output logic              holdEnd,
  output logic              xferStrobe
);

  localparam int unsigned PRE_MOD = ipow(RADIX, PRE_STAGES);
  localparam int PRE_W = (PRE_MOD > 1) ? $clog2(PRE_MOD) : 1;
  localparam int DIG_W = $clog2(RADIX);
  localparam int XF_W  = $clog2(XFER_CYC + 1);

  // free-running prescaler, untouched by the loop restart
  logic [PRE_W-1:0] preCnt;
  logic preWrap;
  assign preWrap  = (preCnt == PRE_W'(PRE_MOD - 1));
  assign baseTick = refTick && preWrap;

  always_ff @(posedge clk) begin
    if (!rstN)        preCnt <= '0;
    else if (refTick) preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  // gate decades: carry[k+1] fires on the tick that wraps decade k
  logic [GATE_STAGES:0] carry;
  assign carry[0] = ctl.gateAdv;

  for (genvar g = 0; g < GATE_STAGES; g++) begin : gDecade
    logic [DIG_W-1:0] digit;
    logic atTop;
    assign atTop      = (digit == DIG_W'(RADIX - 1));
    assign carry[g+1] = carry[g] && atTop;

    always_ff @(posedge clk) begin
      if (!rstN || ctl.gateClr) digit <= '0;
      else if (carry[g])        digit <= atTop ? '0 : digit + 1'b1;
    end
  end

  always_comb begin
    gateEnd = carry[GATE_STAGES];
    for (int k = 0; k < GATE_STAGES; k++)
      if (int'(gateSel) == k) gateEnd = carry[k+1];
  end

  // display hold timer in base ticks
  logic [HOLD_W-1:0] holdCnt;
  logic holdTick;
  assign holdTick = ctl.holdRun && baseTick;
  assign holdEnd  = holdTick && !holdForever && (holdCnt == holdSetting);

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.holdRun)      holdCnt <= '0;
    else if (holdTick && holdCnt != '1) holdCnt <= holdCnt + 1'b1;
  end

  // transfer strobe width counter
  logic [XF_W-1:0] xferLeft;
  assign xferStrobe = (xferLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN)             xferLeft <= '0;
    else if (ctl.xferFire) xferLeft <= XF_W'(XFER_CYC);
    else if (xferStrobe)   xferLeft <= xferLeft - 1'b1;
  end

endmodule

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int RST_CYC = 9000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       gateEnd,
  input  logic       holdEnd,
  input  logic       inhibit,
  input  logic       extMode,
  input  logic       extStart,
  input  logic       extStop,
  input  logic       manualReset,
  input  logic       extTrigger,
  output ctlStrobe_t ctl,
  output phase_t     phase
);

  localparam int RC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;

  phase_t nextPhase;
  logic [RC_W-1:0] rstCnt;
  logic trigPrev;
  logic restartReq;

  assign restartReq = manualReset || (extTrigger && !trigPrev) || holdEnd;

  always_comb begin
    nextPhase   = phase;
    ctl         = '0;
    ctl.gateClr = (phase == PH_CLEAR);
    ctl.holdRun = (phase == PH_HOLD);
    unique case (phase)
      PH_CLEAR: if (rstCnt == RC_W'(RST_CYC - 1)) nextPhase = PH_ARMED;
      PH_ARMED: begin
        if (extMode) begin
          if (extStart) nextPhase = PH_COUNT;
        end else if (baseTick && !inhibit) begin
          nextPhase   = PH_COUNT;
          ctl.gateAdv = 1'b1;   // start tick is the first gate tick
        end
      end
      PH_COUNT: begin
        ctl.gateAdv = baseTick;
        if (extMode ? extStop : gateEnd) begin
          nextPhase    = PH_HOLD;
          ctl.xferFire = 1'b1;
        end
      end
      PH_HOLD: ;
      default: nextPhase = PH_CLEAR;
    endcase
    if (restartReq) begin
      nextPhase = PH_CLEAR;
      if (phase == PH_COUNT) ctl.xferFire = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_CLEAR;
      rstCnt   <= '0;
      trigPrev <= 1'b0;
    end else begin
      phase    <= nextPhase;
      trigPrev <= extTrigger;
      if (phase != PH_CLEAR || restartReq) rstCnt <= '0;
      else                                 rstCnt <= rstCnt + 1'b1;
    end
  end

endmodule

// File: rtl/gated_meas_seq.sv
module gated_meas_seq
  import mseq_pkg::*;
#(
  parameter int RADIX       = 10,
  parameter int PRE_STAGES  = 2,
  parameter int GATE_STAGES = 3,
  parameter int HOLD_W      = 13,
  parameter int RST_CYC     = 9000,
  parameter int XFER_CYC    = 1650,
  parameter int SEL_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic [SEL_W-1:0]  gateSel,
  input  logic [HOLD_W-1:0] holdSetting,
  input  logic              holdForever,
  input  logic              inhibit,
  input  logic              extMode,
  input  logic              extStart,
  input  logic              extStop,
  input  logic              manualReset,
  input  logic              extTrigger,
  output logic              countEnable,
  output logic              counterClear,
  output logic              xferStrobe,
  output logic              displayHold
);

  ctlStrobe_t ctl;
  phase_t     phase;
  logic       baseTick;
  logic       gateEnd;
  logic       holdEnd;

  mseq_ctrl #(.RST_CYC(RST_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .gateEnd(gateEnd),
    .holdEnd(holdEnd), .inhibit(inhibit), .extMode(extMode),
    .extStart(extStart), .extStop(extStop), .manualReset(manualReset),
    .extTrigger(extTrigger), .ctl(ctl), .phase(phase)
  );

  mseq_dp #(
    .RADIX(RADIX), .PRE_STAGES(PRE_STAGES), .GATE_STAGES(GATE_STAGES),
    .HOLD_W(HOLD_W), .XFER_CYC(XFER_CYC), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .refTick(refTick), .gateSel(gateSel),
    .holdSetting(holdSetting), .holdForever(holdForever), .ctl(ctl),
    .baseTick(baseTick), .gateEnd(gateEnd), .holdEnd(holdEnd),
    .xferStrobe(xferStrobe)
  );

  assign countEnable  = (phase == PH_COUNT);
  assign counterClear = (phase == PH_CLEAR);
  assign displayHold  = (phase == PH_HOLD);

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker (
  input logic clk,
  input logic rstN,
  input logic baseTick,
  input logic inhibit,
  input logic extMode,
  input logic manualReset,
  input logic extTrigger,
  input logic holdForever,
  input logic countEnable,
  input logic counterClear,
  input logic xferStrobe,
  input logic displayHold
);

  logic trigSeen;
  always_ff @(posedge clk) begin
    if (!rstN) trigSeen <= 1'b0;
    else       trigSeen <= extTrigger;
  end

  AST_AUTO_START_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countEnable) |-> ($past(extMode) || $past(baseTick))); // R2

  AST_INHIBIT_BLOCKS_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countEnable) |-> ($past(extMode) || !$past(inhibit))); // R3

  AST_XFER_WITH_HOLD_OR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferStrobe) |-> (displayHold || counterClear)); // R6

  AST_ENDLESS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (displayHold && holdForever && !manualReset && !(extTrigger && !trigSeen))
      |=> displayHold); // R8

  AST_MANUAL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    manualReset |=> counterClear); // R9

  AST_XFER_ONLY_FROM_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferStrobe) |-> $past(countEnable)); // R10

  AST_NO_COUNT_IN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    counterClear |-> !countEnable && !displayHold); // R1

endmodule

bind gated_meas_seq mseq_checker u_chk (
  .clk(clk), .rstN(rstN), .baseTick(baseTick), .inhibit(inhibit),
  .extMode(extMode), .manualReset(manualReset), .extTrigger(extTrigger),
  .holdForever(holdForever), .countEnable(countEnable),
  .counterClear(counterClear), .xferStrobe(xferStrobe),
  .displayHold(displayHold)
);

// File: tb/test_gated_meas_seq.sv
module test_gated_meas_seq;

  localparam int RADIX = 4;
  localparam int PRE_STAGES = 1;
  localparam int GATE_STAGES = 3;
  localparam int HOLD_W = 3;
  localparam int RST_CYC = 3;
  localparam int XFER_CYC = 2;
  localparam int SEL_W = 2;
  localparam int RP = 2;                 // clocks per reference tick
  localparam int TB = RP * RADIX;        // clocks per base tick (one prescale decade)
  localparam int LIMIT = 5000;

  logic clk = 1'b0;
  logic rstN;
  logic refTick;
  logic [SEL_W-1:0] gateSel;
  logic [HOLD_W-1:0] holdSetting;
  logic holdForever, inhibit, extMode, extStart, extStop, manualReset, extTrigger;
  logic countEnable, counterClear, xferStrobe, displayHold;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  gated_meas_seq #(
    .RADIX(RADIX), .PRE_STAGES(PRE_STAGES), .GATE_STAGES(GATE_STAGES),
    .HOLD_W(HOLD_W), .RST_CYC(RST_CYC), .XFER_CYC(XFER_CYC), .SEL_W(SEL_W)
  ) i_gated_meas_seq (
    .clk(clk), .rstN(rstN), .refTick(refTick), .gateSel(gateSel),
    .holdSetting(holdSetting), .holdForever(holdForever), .inhibit(inhibit),
    .extMode(extMode), .extStart(extStart), .extStop(extStop),
    .manualReset(manualReset), .extTrigger(extTrigger),
    .countEnable(countEnable), .counterClear(counterClear),
    .xferStrobe(xferStrobe), .displayHold(displayHold)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    refTick = 1'b0;
    for (int ph = 0; ; ph = (ph + 1) % RP) begin
      @(negedge clk);
      refTick = (ph == RP - 1);
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic sigOf(int which);
    case (which)
      0: return countEnable;
      1: return counterClear;
      2: return displayHold;
      default: return xferStrobe;
    endcase
  endfunction

  task automatic waitSig(int which, logic val, output int at);
    int guard = 0;
    while (sigOf(which) != val && guard < LIMIT) begin
      @(negedge clk);
      guard++;
    end
    at = cyc;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseManual();
    @(negedge clk); manualReset = 1'b1;
    @(negedge clk); manualReset = 0;
  endtask

  function automatic int gateTicks(int sel);
    int s = (sel >= GATE_STAGES) ? GATE_STAGES - 1 : sel;
    int r = 1;
    for (int i = 0; i <= s; i++) r = r * RADIX;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int tS, tE, tH, tC, tN, w, seen;
    rstN = 0; gateSel = '0; holdSetting = '0; holdForever = 0; inhibit = 0;
    extMode = 0; extStart = 0; extStop = 0; manualReset = 0; extTrigger = 0;
    step(4);
    chk("R1 clear in reset", counterClear, 1);
    chk("R1 enable in reset", countEnable, 0);
    chk("R1 hold in reset", displayHold, 0);
    chk("R1 strobe in reset", xferStrobe, 0);
    rstN = 1;

    // exhaustive sweep of gate select against hold setting
    for (int sel = 0; sel < 4; sel++) begin
      for (int h = 0; h < (1 << HOLD_W); h++) begin
        gateSel = SEL_W'(sel); holdSetting = HOLD_W'(h);
        pulseManual();
        waitSig(0, 1'b1, tS);
        waitSig(0, 1'b0, tE);
        chk("R4 gate width", tE - tS, (gateTicks(sel) - 1) * TB);
        chk("R6 strobe at gate end", xferStrobe, 1);
        chk("R6 hold at gate end", displayHold, 1);
        w = 0;
        while (xferStrobe && w < LIMIT) begin w++; step(1); end
        chk("R6 strobe width", w, XFER_CYC);
        waitSig(2, 1'b0, tH);
        chk("R7 hold width", tH - tE, (h + 1) * TB);
        chk("R1 clear after hold", counterClear, 1);
        waitSig(1, 1'b0, tC);
        chk("R1 clear width", tC - tH, RST_CYC);
        waitSig(0, 1'b1, tN);
        chk("R7 loop period", tN - tS, (gateTicks(sel) + h + 1) * TB);
        chk("R2 restart", countEnable, 1);
      end
    end

    // abort mid gate, then a full gate
    gateSel = 2'd1; holdSetting = '0;
    pulseManual();
    waitSig(0, 1'b1, tS);
    step(5 * TB + 3);
    pulseManual();
    chk("R10 strobe on abort while counting", xferStrobe, 1);
    chk("R9 clear after manual", counterClear, 1);
    chk("R9 enable off after manual", countEnable, 0);
    waitSig(0, 1'b1, tS);
    waitSig(0, 1'b0, tE);
    chk("R5 full gate after abort", tE - tS, (gateTicks(1) - 1) * TB);
    step(3);
    pulseManual();
    chk("R10 no strobe on abort in hold", xferStrobe, 0);
    chk("R9 clear from hold", counterClear, 1);

    // external trigger edge during hold, held high
    waitSig(0, 1'b1, tS);
    waitSig(0, 1'b0, tE);
    step(3);
    extTrigger = 1'b1;
    step(1);
    chk("R9 clear on trigger edge", counterClear, 1);
    step(RST_CYC + 1);
    chk("R9 steady trigger single clear", counterClear, 0);
    extTrigger = 0;

    // inhibit
    inhibit = 1'b1;
    pulseManual();
    seen = 0;
    for (int i = 0; i < 10 * TB; i++) begin step(1); seen += int'(countEnable); end
    chk("R3 no start under inhibit", seen, 0);
    inhibit = 0;
    tE = cyc;
    waitSig(0, 1'b1, tS);
    chk("R3 start within one base period", (tS - tE >= 1 && tS - tE <= TB) ? 1 : 0, 1);

    // endless hold
    holdForever = 1'b1; gateSel = '0;
    pulseManual();
    waitSig(0, 1'b1, tS);
    waitSig(0, 1'b0, tE);
    seen = 0;
    for (int i = 0; i < 20 * TB; i++) begin step(1); seen += int'(!displayHold); end
    chk("R8 hold persists", seen, 0);
    pulseManual();
    chk("R8 manual ends endless hold", counterClear, 1);
    holdForever = 0;

    // external mode
    extMode = 1'b1;
    pulseManual();
    seen = 0;
    for (int i = 0; i < 10 * TB; i++) begin step(1); seen += int'(countEnable); end
    chk("R11 no auto start", seen, 0);
    @(negedge clk); extStart = 1'b1;
    @(negedge clk); extStart = 0;
    chk("R11 start opens gate", countEnable, 1);
    seen = 0;
    for (int i = 0; i < 20 * TB; i++) begin step(1); seen += int'(!countEnable); end
    chk("R11 gate length ignored", seen, 0);
    @(negedge clk); extStop = 1'b1;
    @(negedge clk); extStop = 0;
    chk("R11 stop closes gate", countEnable, 0);
    chk("R11 stop strobes", xferStrobe, 1);
    chk("R11 stop enters hold", displayHold, 1);
    @(negedge clk); extStart = 1'b1;
    @(negedge clk); extStart = 0;
    chk("R11 start ignored in hold", countEnable, 0);
    extMode = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule